// File: doc/BRIEF.md
# Dual-Channel Data-Ready Latch Controller

The block sits between two converter channels and a serial reader. Each channel delivers a result word together with a one-cycle completion strobe. The block keeps each result in a first-stage latch. It releases results to a second-stage output latch and announces them on a shared active-low ready line, which is one modulator-clock cycle wide. A two-bit mode input selects which completions raise the ready line. In the default paired mode the block waits for both channels and fires once, when the later channel completes. A drive-select input chooses between a floating line and a line driven high while the line is idle, so several blocks can share one line through a pull-up.

The serial reader marks the start and the end of a read on one channel with strobes. While a read is open, that channel's output word is frozen. A result released during the read waits in the first stage and moves to the output after the read ends. The ready pulses keep coming during a read.

Top module: `drdy_pair_latch`

## Requirements
- R1: A completion event sampled at clock edge k drives `rdy_n_o` low for exactly the one cycle that follows edge k+1. Events spaced two or more cycles apart each give a separate one-cycle pulse.
- R2: With `mode_i` = 2'b00 (the reset default), a single pulse is issued once both channels have completed since the last pulse. The pulse is timed to the later strobe, or to the common strobe when both arrive together. Both output words change at edge k+1.
- R3: With `mode_i` = 2'b01 only channel 0 strobes cause pulses. With 2'b10 only channel 1 strobes cause pulses. In both modes each channel's word still moves to its output at edge k+1 after its own strobe.
- R4: With `mode_i` = 2'b11 a strobe on either channel causes a pulse, and a strobe on both channels at once causes one pulse.
- R5: `rdy_oe_o` is 1 during a pulse. Outside a pulse it equals `drive_hi_i`, and `rdy_n_o` is then 1.
- R6: While `rst_ni` is low, `rdy_n_o` is 1, `rdy_oe_o` equals `drive_hi_i`, both words read 0, and strobes are discarded.
- R7: A read start on channel `rd_ch_i` (0 selects channel 0, 1 selects channel 1) freezes that channel's output word. The word stays frozen from the start edge through the edge where the matching done strobe is sampled.
- R8: A result released while its channel is frozen is moved to the output at the edge after the done strobe. The newest first-stage word for that channel is the one moved.
- R9: Ready pulses keep their R1 to R4 timing while a read is open.
- R10: In paired mode, a second strobe from the same channel before its partner arrives replaces the held word and does not add a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Ready-pulse mode: 00 pair, 01 channel 0, 10 channel 1, 11 either |
| drive_hi_i | input | 1 | 1 drives the idle line high, 0 lets it float |
| ch0_valid_i | input | 1 | Channel 0 completion strobe |
| ch0_data_i | input | W | Channel 0 result |
| ch1_valid_i | input | 1 | Channel 1 completion strobe |
| ch1_data_i | input | W | Channel 1 result |
| rd_start_i | input | 1 | Read start strobe for channel `rd_ch_i` |
| rd_ch_i | input | 1 | Channel addressed by the start and done strobes |
| rd_done_i | input | 1 | Read complete strobe for channel `rd_ch_i` |
| rdy_n_o | output | 1 | Ready line level, active low |
| rdy_oe_o | output | 1 | Ready line output enable |
| word0_o | output | W | Channel 0 output word |
| word1_o | output | W | Channel 1 output word |

## Verification
A strobe sampled at edge k moves its word to the output at edge k+1 and holds the ready line low from edge k+1 to edge k+2. A word deferred by a read moves at the edge after the done strobe. The bench drives inputs on falling edges and advances a behavioural model by one step per rising edge. It compares every output at the next falling edge, so each of these delays lands in the exact cycle the model predicts. Pulse counts over mode segments are also checked against counts derived directly from the strobes sent.

// File: rtl/drl_pkg.sv
package drl_pkg;
  typedef enum logic [1:0] {
    DRM_PAIR = 2'b00,
    DRM_CH0  = 2'b01,
    DRM_CH1  = 2'b10,
    DRM_ANY  = 2'b11
  } drm_e;

  localparam int unsigned NCH = 2;
endpackage

// File: rtl/drl_capture.sv
module drl_capture
  import drl_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic [NCH-1:0]           valid_i,
  input  logic [NCH-1:0][W-1:0]    data_i,
  output logic [NCH-1:0][W-1:0]    s1_o,
  output logic [NCH-1:0]           rel_o,
  output logic                     evt_o
);
  drm_e                 mode;
  logic [NCH-1:0]       got_q;
  logic                 pair_evt;

  assign mode     = drm_e'(mode_i);
  assign pair_evt = (mode == DRM_PAIR) && (&(got_q | valid_i));

  always_comb begin
    unique case (mode)
      DRM_PAIR: begin rel_o = {NCH{pair_evt}}; evt_o = pair_evt;   end
      DRM_CH0:  begin rel_o = valid_i;         evt_o = valid_i[0]; end
      DRM_CH1:  begin rel_o = valid_i;         evt_o = valid_i[1]; end
      default:  begin rel_o = valid_i;         evt_o = |valid_i;   end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_o  <= '0;
      got_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (valid_i[c]) s1_o[c] <= data_i[c];
      // arrival record only meaningful while pairing
      if (mode != DRM_PAIR || pair_evt) got_q <= '0;
      else                              got_q <= got_q | valid_i;
    end
  end

  // R2: a complete pair never lingers unannounced
  p_pair_fires_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == DRM_PAIR) |-> !(&got_q));
endmodule

// File: rtl/drl_hold.sv
module drl_hold #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rel_i,
  input  logic [W-1:0] s1_i,
  input  logic         start_i,
  input  logic         done_i,
  output logic [W-1:0] word_o
);
  logic pend_q, lock_q, xfer;

  // a start on this edge already freezes the word
  assign xfer = pend_q && !lock_q && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lock_q <= 1'b0;
      word_o <= '0;
    end else begin
      if (start_i)     lock_q <= 1'b1;
      else if (done_i) lock_q <= 1'b0;
      if (rel_i)       pend_q <= 1'b1;
      else if (xfer)   pend_q <= 1'b0;
      if (xfer)        word_o <= s1_i;
    end
  end

  p_hold_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(word_o));

  p_change_needs_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> $past(pend_q));
endmodule

// File: rtl/drl_pin.sv
module drl_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic drive_hi_i,
  output logic rdy_n_o,
  output logic rdy_oe_o
);
  logic evt_q, pulse_q;

  // two stages so the pulse lines up with the word update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      evt_q   <= evt_i;
      pulse_q <= evt_q;
    end
  end

  assign rdy_n_o  = ~pulse_q;
  assign rdy_oe_o = drive_hi_i | pulse_q;
endmodule

// File: rtl/drdy_pair_latch.sv
module drdy_pair_latch
  import drl_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         drive_hi_i,
  input  logic         ch0_valid_i,
  input  logic [W-1:0] ch0_data_i,
  input  logic         ch1_valid_i,
  input  logic [W-1:0] ch1_data_i,
  input  logic         rd_start_i,
  input  logic         rd_ch_i,
  input  logic         rd_done_i,
  output logic         rdy_n_o,
  output logic         rdy_oe_o,
  output logic [W-1:0] word0_o,
  output logic [W-1:0] word1_o
);
  logic [NCH-1:0]        valid, rel;
  logic [NCH-1:0][W-1:0] data, s1, words;
  logic                  evt;

  assign valid = {ch1_valid_i, ch0_valid_i};
  assign data  = {ch1_data_i, ch0_data_i};

  drl_capture #(.W(W)) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .valid_i(valid), .data_i(data),
    .s1_o(s1), .rel_o(rel), .evt_o(evt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    drl_hold #(.W(W)) u_hold (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .rel_i(rel[c]), .s1_i(s1[c]),
      .start_i(rd_start_i && (rd_ch_i == 1'(c))),
      .done_i(rd_done_i && (rd_ch_i == 1'(c))),
      .word_o(words[c])
    );
  end

  drl_pin u_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt),
    .drive_hi_i(drive_hi_i), .rdy_n_o(rdy_n_o), .rdy_oe_o(rdy_oe_o)
  );

  assign word0_o = words[0];
  assign word1_o = words[1];

  // R5: a floating line is never low
  p_float_only_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_oe_o |-> rdy_n_o);
endmodule

// File: tb/drdy_pair_latch_bench.sv
module drdy_pair_latch_bench;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         drive_hi = 1'b0;
  logic         v0 = 1'b0, v1 = 1'b0;
  logic [W-1:0] d0 = '0, d1 = '0;
  logic         st = 1'b0, ch = 1'b0, dn = 1'b0;
  logic         rdy_n, rdy_oe;
  logic [W-1:0] w0, w1;

  int checks = 0, errors = 0, pulses = 0;
  string cur_req = "R6";
  bit finished = 1'b0;

  // behavioural reference state
  int m_s1[2], m_word[2];
  bit m_pend[2], m_lock[2], m_seen[2];
  bit m_ev_prev, m_low;
  int seq = 'h100;

  always #5ns clk = ~clk;

  drdy_pair_latch #(.W(W)) u_drdy_pair_latch (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .drive_hi_i(drive_hi),
    .ch0_valid_i(v0), .ch0_data_i(d0), .ch1_valid_i(v1), .ch1_data_i(d1),
    .rd_start_i(st), .rd_ch_i(ch), .rd_done_i(dn),
    .rdy_n_o(rdy_n), .rdy_oe_o(rdy_oe), .word0_o(w0), .word1_o(w1)
  );

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit ev;
    bit rel[2];
    bit vin[2];
    vin[0] = v0; vin[1] = v1;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_s1[c] = 0; m_word[c] = 0; m_pend[c] = 0; m_lock[c] = 0; m_seen[c] = 0;
      end
      m_ev_prev = 0; m_low = 0;
      return;
    end
    case (mode)
      2'b00: begin
        ev = (m_seen[0] || v0) && (m_seen[1] || v1);
        rel[0] = ev; rel[1] = ev;
      end
      2'b01: begin ev = v0; rel[0] = v0; rel[1] = v1; end
      2'b10: begin ev = v1; rel[0] = v0; rel[1] = v1; end
      default: begin ev = v0 || v1; rel[0] = v0; rel[1] = v1; end
    endcase
    m_low = m_ev_prev;
    m_ev_prev = ev;
    for (int c = 0; c < 2; c++) begin
      bit start_c, done_c, moved;
      start_c = st && (ch == c[0]);
      done_c  = dn && (ch == c[0]);
      moved = m_pend[c] && !m_lock[c] && !start_c;
      if (moved) m_word[c] = m_s1[c];
      if (start_c) m_lock[c] = 1; else if (done_c) m_lock[c] = 0;
      if (rel[c]) m_pend[c] = 1; else if (moved) m_pend[c] = 0;
    end
    if (v0) m_s1[0] = int'(d0);
    if (v1) m_s1[1] = int'(d1);
    if (mode != 2'b00 || ev) begin m_seen[0] = 0; m_seen[1] = 0; end
    else begin m_seen[0] |= vin[0]; m_seen[1] |= vin[1]; end
  endtask

  task automatic compare();
    check("rdy_n_o", int'(rdy_n), int'(!m_low));
    check("rdy_oe_o", int'(rdy_oe), int'(drive_hi || m_low));
    check("word0_o", int'(w0), m_word[0]);
    check("word1_o", int'(w1), m_word[1]);
    if (!rdy_n) pulses++;
  endtask

  // one clock: inputs set after a falling edge, checked at the next one
  task automatic cyc(bit a0 = 0, bit a1 = 0, bit s = 0, bit c = 0, bit d = 0);
    v0 = a0; v1 = a1; st = s; ch = c; dn = d;
    if (a0) begin d0 = W'(seq); seq += 'h11; end
    if (a1) begin d1 = W'(seq); seq += 'h13; end
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R6: strobes during reset are discarded
    cur_req = "R6";
    cyc(1, 1); cyc(1, 0); cyc(0, 1); idle(2);
    drive_hi = 1'b1; idle(1);
    rst_n = 1'b1;

    // R1 R2 pair timed to the later channel
    cur_req = "R1 R2";
    pulses = 0;
    cyc(1, 0); idle(3); cyc(0, 1); idle(4);
    cyc(1, 1); idle(4);
    check("pair pulses", pulses, 2);

    // R10 repeated channel before partner
    cur_req = "R10";
    pulses = 0;
    cyc(1, 0); idle(2); cyc(1, 0); idle(2); cyc(0, 1); idle(4);
    check("repeat pulses", pulses, 1);

    // R3 single-channel modes, line floating when idle (R5)
    drive_hi = 1'b0;
    cur_req = "R3 R5";
    mode = 2'b01; pulses = 0;
    cyc(1, 0); idle(3); cyc(0, 1); idle(3); cyc(1, 0); idle(3); cyc(0, 1); idle(3); cyc(1, 0); idle(3);
    check("ch0 mode pulses", pulses, 3);
    mode = 2'b10; pulses = 0;
    cyc(1, 0); idle(3); cyc(0, 1); idle(3); cyc(1, 1); idle(3);
    check("ch1 mode pulses", pulses, 2);

    // R4 either channel
    cur_req = "R4";
    mode = 2'b11; pulses = 0;
    cyc(1, 0); idle(2); cyc(0, 1); idle(2); cyc(1, 1); idle(3);
    check("any mode pulses", pulses, 3);

    // R7 R8 R9 read interlock in paired mode
    cur_req = "R7 R8 R9";
    mode = 2'b00; drive_hi = 1'b1; pulses = 0;
    cyc(1, 1); idle(3);
    cyc(0, 0, 1, 0);            // freeze channel 0
    cyc(1, 1); idle(3);
    cyc(1, 0); idle(1); cyc(0, 1); idle(3);
    check("pulses during read", pulses, 3);
    cyc(0, 0, 0, 0, 1);         // release channel 0
    idle(3);
    cyc(0, 0, 1, 1);            // freeze channel 1, start same edge as nothing pending
    cyc(1, 1); idle(1);
    cyc(1, 1, 0, 1, 1);         // done coincides with a new pair
    idle(4);
    cyc(1, 1, 1, 0);            // start on the edge a release lands
    idle(3);
    cyc(0, 0, 0, 0, 1); idle(3);

    // R6 reset mid-run clears words and stops pulses
    cur_req = "R6";
    cyc(1, 1);
    rst_n = 1'b0;
    cyc(1, 1); cyc(0, 0); idle(2);
    check("word0 after reset", int'(w0), 0);
    rst_n = 1'b1;
    cur_req = "R1 R2";
    cyc(1, 1); idle(3);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule